// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block turns three sources of trouble into a clean system reset and a watchdog alarm. An external comparator supplies a one-bit supply-good flag. A push-button supplies an active-low manual reset pin. A serial bus front end supplies single-cycle strobes that mark each start and each stop event. The block drives the reset out in both polarities. Reset is held while either cause is present. After the last cause clears, reset is stretched for a selectable number of slow ticks.

The watchdog counts slow ticks once the system reset is released. The processor keeps the watchdog quiet by completing any bus transaction, which is a start event followed later by a stop event. If no such pair arrives within the selected period, the active-low watchdog-fail output goes low. It stays low until the next restart.

All durations are counted in periods of the `tick` strobe and are multiplied by `UNIT_TICKS`, which represents 25 ms of time. All inputs and outputs are plain control pins, so there is no stream interface and no back-pressure. In the requirements, "U" stands for `UNIT_TICKS` and "D" stands for `DEB_LEN`.

Top module: `supv_reset_ctl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `rst_out_n` is 0, `rst_out` is 1 and `wd_fail_n` is 1.
- R2: In any cycle where `supply_ok` is 0, `rst_out_n` is 0 and `rst_out` is 1, in that same cycle with no register in the path.
- R3: Reset stretch after the causes clear. The first clock edge after every cause is gone loads the stretch count from `dly_sel`: 00 gives 2U ticks, 01 gives 8U, 10 gives 16U and 11 gives 32U. Reset is released right after the edge that samples the last of those ticks. Ticks that arrive while a cause is present, or in the load cycle, are not counted.
- R4: `mr_n` passes through two synchronizer flops and is then debounced. Reset asserts on the (D+2)th clock edge after `mr_n` goes low, provided `mr_n` stays low. A low pulse shorter than D cycles has no effect on the outputs.
- R5: While the debounced manual reset is low, reset stays active whatever ticks arrive. After `mr_n` is released, the debounced input follows after D+2 edges, and then the R3 stretch applies.
- R6: A restart happens on the second clock edge after a `bus_stop` strobe, provided a `bus_start` strobe was seen after the previous restart. A `bus_stop` with no preceding `bus_start` does nothing.
- R7: Each restart reloads the watchdog from `wd_sel`: 00 gives 56U ticks, 01 gives 8U and 10 gives 1U. When that number of ticks has been sampled with no restart, `wd_fail_n` goes low right after the edge that samples the last tick.
- R8: Once low, `wd_fail_n` stays low through further ticks. A restart returns it to 1.
- R9: With `wd_sel` = 11 latched at a reload, the watchdog is off and `wd_fail_n` stays 1.
- R10: A change of `dly_sel` or `wd_sel` takes effect only at the next reload of that counter. A delay already counting keeps its loaded length.
- R11: While system reset is active, the watchdog is held. `wd_fail_n` is 1 and the counter reloads every cycle, so ticks during reset never cause a watchdog failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tick | input | 1 | Slow time-base strobe, one clock wide |
| supply_ok | input | 1 | Supply-good flag from the external comparator |
| mr_n | input | 1 | Manual reset pin, active low, asynchronous |
| bus_start | input | 1 | Bus start-event strobe |
| bus_stop | input | 1 | Bus stop-event strobe |
| dly_sel | input | 2 | Reset stretch select |
| wd_sel | input | 2 | Watchdog period select, 11 turns it off |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |
| wd_fail_n | output | 1 | Watchdog failure, active low |

## Verification
Each result has a known due cycle, and the checks are placed to match it:
- **Supply loss:** the reset outputs react to `supply_ok` within the same cycle, so the bench samples 1 ns after driving that input.
- **Manual reset press:** reset is due on the (D+2)th edge. The bench samples once after D+1 edges, expecting reset still inactive, and once after D+2 edges, expecting it active.
- **Stretch and watchdog expiry:** the bench pulses `tick` itself, one clock wide with one idle clock between pulses. It samples the outputs after N-1 ticks, expecting no change, and again after N ticks, expecting the change.
- **Restart:** the watchdog clears two edges after `bus_stop`. The bench holds `tick` low for longer than that before it samples.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // Stretch length in units of 25 ms, per select code.
  function automatic int dly_units(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

  // Watchdog period in units of 25 ms; code 11 means off.
  function automatic int wd_units(input logic [1:0] code);
    case (code)
      2'b00:   return 56;
      2'b01:   return 8;
      2'b10:   return 1;
      default: return 0;
    endcase
  endfunction

  localparam logic [1:0] WD_OFF = 2'b11;
  localparam int MAX_UNITS = 56;
endpackage

// File: rtl/mr_debounce.sv
module mr_debounce #(
  parameter int DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n,
  output logic mr_act
);
  localparam int DW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam logic [DW-1:0] LAST = DW'(DEB_LEN - 1);

  logic s1, s2, deb;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      deb <= 1'b1;
      cnt <= '0;
    end else begin
      s1 <= mr_n;
      s2 <= s1;
      if (s2 != deb) begin
        if (cnt == LAST) begin
          deb <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign mr_act = ~deb;

  // The debounced level only moves to a level the synchronizer already held.
  AST_DEB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb) |-> ($past(s2) != $past(deb)));  // R4
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int UNIT_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cause,
  input  logic [1:0] sel,
  output logic       hold
);
  import supv_pkg::*;
  localparam int CW = $clog2(32 * UNIT_TICKS + 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  assign load_val = CW'(dly_units(sel) * UNIT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= 1'b1;
      armed <= 1'b0;
      cnt   <= '0;
    end else if (cause) begin
      hold  <= 1'b1;
      armed <= 1'b0;
    end else if (hold && !armed) begin
      cnt   <= load_val;   // R10: select sampled only here
      armed <= 1'b1;
    end else if (hold && tick) begin
      if (cnt <= CW'(1)) begin
        hold  <= 1'b0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> hold);  // R2
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(tick) && !$past(cause) && $past(armed)));  // R3
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !armed) |=> hold);  // R5
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int UNIT_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sys_rst,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [1:0] sel,
  output logic       fail
);
  import supv_pkg::*;
  localparam int CW = $clog2(MAX_UNITS * UNIT_TICKS + 1);

  logic          start_q, stop_q, seen_start, en;
  logic          restart, reload;
  logic [CW-1:0] cnt;

  assign restart = stop_q && seen_start;
  assign reload  = sys_rst || restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= bus_start;
      stop_q  <= bus_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_start <= 1'b0;
      en         <= 1'b0;
      fail       <= 1'b0;
      cnt        <= '0;
    end else if (reload) begin
      seen_start <= 1'b0;
      en         <= (sel != WD_OFF);
      fail       <= 1'b0;
      cnt        <= CW'(wd_units(sel) * UNIT_TICKS);
    end else begin
      if (start_q) seen_start <= 1'b1;
      if (tick && en && !fail) begin
        if (cnt <= CW'(1)) fail <= 1'b1;
        else cnt <= cnt - 1'b1;
      end
    end
  end

  AST_FAIL_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($past(tick) && $past(en)));  // R7
  AST_FAIL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !reload) |=> fail);  // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reload) |=> !fail);  // R9
  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !fail);  // R11
endmodule

// File: rtl/supv_reset_ctl.sv
module supv_reset_ctl #(
  parameter int UNIT_TICKS = 1,
  parameter int DEB_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       mr_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [1:0] dly_sel,
  input  logic [1:0] wd_sel,
  output logic       rst_out_n,
  output logic       rst_out,
  output logic       wd_fail_n
);
  logic mr_act, cause, hold, sys_rst, fail;

  mr_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .mr_act(mr_act));

  assign cause = !supply_ok || mr_act;

  rst_stretch #(.UNIT_TICKS(UNIT_TICKS)) u_str (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cause(cause),
    .sel(dly_sel), .hold(hold));

  // Causes reach the pins without a register (R2, R4).
  assign sys_rst   = cause || hold;
  assign rst_out   = sys_rst;
  assign rst_out_n = ~sys_rst;

  wdog_timer #(.UNIT_TICKS(UNIT_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sys_rst(sys_rst),
    .bus_start(bus_start), .bus_stop(bus_stop), .sel(wd_sel), .fail(fail));

  assign wd_fail_n = ~fail;

  AST_RESET_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rst_out);  // R1
endmodule

// File: tb/sim_supv_reset_ctl.sv
module sim_supv_reset_ctl;
  localparam int U = 1;
  localparam int D = 4;

  logic clk = 0, rst_n = 0, tick = 0, supply_ok = 1, mr_n = 1;
  logic bus_start = 0, bus_stop = 0;
  logic [1:0] dly_sel = 2'b01, wd_sel = 2'b11;
  logic rst_out_n, rst_out, wd_fail_n;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  supv_reset_ctl #(.UNIT_TICKS(U), .DEB_LEN(D)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .mr_n(mr_n),
    .bus_start(bus_start), .bus_stop(bus_stop), .dly_sel(dly_sel), .wd_sel(wd_sel),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_fail_n(wd_fail_n));

  // {select code, expected ticks}
  localparam logic [9:0] DLY_VEC [4] = '{
    {2'b00, 8'(2*U)}, {2'b01, 8'(8*U)}, {2'b10, 8'(16*U)}, {2'b11, 8'(32*U)}};
  localparam logic [9:0] WD_VEC [3] = '{
    {2'b00, 8'(56*U)}, {2'b01, 8'(8*U)}, {2'b10, 8'(1*U)}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk);
      tick = 0; @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_wd();
    bus_start = 1; @(negedge clk); bus_start = 0; idle(1);
    bus_stop = 1;  @(negedge clk); bus_stop = 0;  idle(2);
  endtask

  // Drops the supply, then checks the stretch; n = expected ticks.
  task automatic power_blip(input int n, input string req);
    supply_ok = 0; #1;
    chk(rst_out_n == 0 && rst_out == 1, "R2", rst_out_n, 0);
    @(negedge clk); supply_ok = 1; idle(2);
    ticks(n - 1);
    chk(rst_out_n == 0, req, rst_out_n, 0);
    ticks(1);
    chk(rst_out_n == 1 && rst_out == 0, req, rst_out_n, 1);
  endtask

  initial begin
    int waited = 0;
    while (waited < 200000) begin @(posedge clk); waited++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit glitch;
    idle(3);
    chk(rst_out_n == 0 && rst_out == 1 && wd_fail_n == 1, "R1", rst_out_n, 0);
    rst_n = 1; idle(1);
    chk(rst_out_n == 0 && rst_out == 1 && wd_fail_n == 1, "R1", rst_out_n, 0);
    // Power-up stretch at default code 01: load cycle already passed.
    ticks(8*U - 1);
    chk(rst_out_n == 0, "R3 power-up", rst_out_n, 0);
    ticks(1);
    chk(rst_out_n == 1, "R3 power-up", rst_out_n, 1);

    // Table walk: every stretch code.
    for (int i = 0; i < 4; i++) begin
      dly_sel = DLY_VEC[i][9:8];
      power_blip(int'(DLY_VEC[i][7:0]), "R3");
    end

    // R10: change during a running stretch keeps the loaded length.
    dly_sel = 2'b00;
    supply_ok = 0; @(negedge clk); supply_ok = 1; idle(2);
    dly_sel = 2'b11;
    ticks(2*U - 1);
    chk(rst_out_n == 0, "R10", rst_out_n, 0);
    ticks(1);
    chk(rst_out_n == 1, "R10", rst_out_n, 1);
    power_blip(32*U, "R10 next load");

    // R4: short manual pulse ignored.
    dly_sel = 2'b00;
    glitch = 0;
    mr_n = 0; idle(D - 2); mr_n = 1;
    for (int i = 0; i < D + 6; i++) begin
      @(negedge clk); if (rst_out_n == 0) glitch = 1;
    end
    chk(!glitch, "R4 short pulse", glitch, 0);

    // R4/R5: long hold.
    mr_n = 0; idle(D + 1);
    chk(rst_out_n == 1, "R4 before debounce", rst_out_n, 1);
    idle(1);
    chk(rst_out_n == 0 && rst_out == 1, "R4 asserted", rst_out_n, 0);
    ticks(40*U);
    chk(rst_out_n == 0, "R5 held", rst_out_n, 0);
    mr_n = 1; idle(D + 4);
    ticks(2*U - 1);
    chk(rst_out_n == 0, "R5 stretch", rst_out_n, 0);
    ticks(1);
    chk(rst_out_n == 1, "R5 released", rst_out_n, 1);

    // R11: ticks during reset never fail the watchdog.
    wd_sel = 2'b10;
    supply_ok = 0; ticks(3);
    chk(wd_fail_n == 1, "R11", wd_fail_n, 1);
    supply_ok = 1; idle(2); ticks(2*U);
    chk(rst_out_n == 1 && wd_fail_n == 1, "R11 reload", wd_fail_n, 1);
    ticks(1);
    chk(wd_fail_n == 0, "R7 after reset", wd_fail_n, 0);

    // Table walk: watchdog periods.
    for (int i = 0; i < 3; i++) begin
      wd_sel = WD_VEC[i][9:8];
      restart_wd();
      chk(wd_fail_n == 1, "R8 restart clears", wd_fail_n, 1);
      ticks(int'(WD_VEC[i][7:0]) - 1);
      chk(wd_fail_n == 1, "R7 early", wd_fail_n, 1);
      ticks(1);
      chk(wd_fail_n == 0, "R7 expiry", wd_fail_n, 0);
    end

    // R8: stays low; R6: stop without start ignored.
    ticks(5);
    chk(wd_fail_n == 0, "R8 sticky", wd_fail_n, 0);
    bus_stop = 1; @(negedge clk); bus_stop = 0; idle(3);
    chk(wd_fail_n == 0, "R6 lone stop", wd_fail_n, 0);
    restart_wd();
    chk(wd_fail_n == 1, "R6 start-stop", wd_fail_n, 1);

    // R10: new code waits for the reload.
    wd_sel = 2'b00;
    ticks(1);
    chk(wd_fail_n == 0, "R10 old period", wd_fail_n, 0);

    // R9: watchdog off.
    wd_sel = 2'b11;
    restart_wd();
    ticks(60*U);
    chk(wd_fail_n == 1, "R9 off", wd_fail_n, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule